// File: doc/BRIEF.md
# Half-Bridge PWM with Fault Shutdown

This block drives one half-bridge leg. An 8-bit timer runs through a prescaler that divides by 1, 4 or 16. It wraps at a programmable period value. Each timer count is divided into four sub-steps, so the duty cycle has 10 bits of resolution. The PWM level drives output A, and output B carries its complement. A programmable dead-band interval keeps both outputs low before either one rises. After dead-band insertion, each output can be inverted on its own.

A set of selectable fault inputs overrides the pins. When a selected fault is active, the block latches a shutdown status and drives each pin to a programmed safe state: driven low, driven high, or released (output enable low). The status can be cleared by a register write. It can also clear itself at a period boundary once the fault has gone away. In both cases the pins go back to PWM only when a new period starts. A clock-enable input freezes the whole block. Software sets the block up through a small write-only register port.

Top module: `hb_pwm_guard`

## Requirements
- R1: After reset all registers are zero, and pwm_a, pwm_a_oe, pwm_b, pwm_b_oe, period_hit and shut_active are all low.
- R2: The timer advances one sub-step each time the prescaler expires. Register 2 bits [3:2] select the divisor: 00 gives 1, 01 gives 4, 10 or 11 gives 16. A period covers (P+1)*4 sub-steps, where P is register 0. period_hit is high for exactly one cycle, the cycle just after the timer wraps to zero.
- R3: The duty value D is {register 1, register 2 bits [1:0]}. The PWM level is high while the 10-bit position {timer, sub-step} is below D.
- R4: A new duty value takes effect only when the timer wraps. The rest of the current period keeps the old value.
- R5: Output A follows the PWM level and output B follows its complement. When the level changes, both outputs are low for N enabled cycles, where N is register 3 bits [6:0]. The output that is becoming active then goes high. The pins are updated one cycle after the level changes, and A and B are never high together.
- R6: Register 2 bit 4 inverts pin A and bit 5 inverts pin B. The inversion is applied after dead-band insertion and has no effect on the shutdown states.
- R7: While register 2 bit 6 (output enable) is 0, both pins are low and both output enables are low.
- R8: Register 4 bits [2:0] select which fault inputs count. A selected input that is high sets shut_active on the next enabled edge and forces the pins at that same edge. An unselected input has no effect.
- R9: While the pins are forced, register 4 bits [4:3] set pin A and bits [6:5] set pin B. The codes are: 00 drives low, 01 drives high, 1x gives output enable low with the pin low.
- R10: Writing register 4 with bit 7 = 1 sets shut_active. Writing it with bit 7 = 0 clears shut_active when no selected fault is active. The pins stay forced until the next timer wrap.
- R11: When register 3 bit 7 (auto-restart) is set, shut_active clears at a timer wrap with no selected fault active. The pins are released at that same edge.
- R12: While clk_en is low, no counter, register, status or pin changes, writes are ignored, and period_hit stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; low freezes the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index (0 period, 1 duty high, 2 control, 3 dead-band, 4 shutdown) |
| wr_data | input | 8 | Write data |
| fault_in | input | 3 | Fault inputs, active high |
| pwm_a | output | 1 | Output A level |
| pwm_a_oe | output | 1 | Output A drive enable |
| pwm_b | output | 1 | Output B level |
| pwm_b_oe | output | 1 | Output B drive enable |
| period_hit | output | 1 | One-cycle pulse after each timer wrap |
| shut_active | output | 1 | Latched shutdown status |

## Verification
The duty and dead-band path is run with a 6/16 duty and a 2-cycle gap, and the high and overlap counts are measured over one period. This separates an off-by-one in the duty comparison from one in the dead-band counter. The period is checked at prescale 1 and at prescale 4, which shows whether the divisor scales the timer or only the sub-steps. A duty change written in mid-period, and the polarity flip, show whether the buffering and the inversion sit in the right place. Faults are applied on an unselected input, on a selected one, by software force, by software clear and with auto-restart. Each case separates the status from the pin release, which must wait for a period boundary.

// File: rtl/hb_pwm_guard.sv
module hb_pwm_guard #(
  parameter int DW   = 8,
  parameter int TW   = 8,
  parameter int DBW  = 7,
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_en,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [NSRC-1:0] fault_in,
  output logic            pwm_a,
  output logic            pwm_a_oe,
  output logic            pwm_b,
  output logic            pwm_b_oe,
  output logic            period_hit,
  output logic            shut_active
);
  localparam int PW = TW + 2;

  logic [TW-1:0]   per_r, dhi_r, tmr;
  logic [1:0]      dlo_r, psel_r, q;
  logic            pol_a_r, pol_b_r, en_r, auto_r;
  logic [DBW-1:0]  dead_r, dcnt;
  logic [NSRC-1:0] src_r;
  logic [1:0]      st_a_r, st_b_r;
  logic [3:0]      psc, div_m1;
  logic [PW-1:0]   duty_act;
  logic            sel, wait_r, a_int, b_int, sd, forced, sd_n;
  logic            step, wrap, raw, fault_hit, wr_shut;

  assign div_m1    = (psel_r == 2'd0) ? 4'd0 : (psel_r == 2'd1) ? 4'd3 : 4'd15;
  assign step      = clk_en && (psc == div_m1);
  assign wrap      = step && (q == 2'd3) && (tmr == per_r);
  assign raw       = {tmr, q} < duty_act;
  assign fault_hit = |(fault_in & src_r);
  assign wr_shut   = clk_en && wr_en && (wr_addr == 3'd4);

  always_comb begin
    sd_n = sd;
    if (fault_hit)             sd_n = 1'b1;
    else if (wr_shut)          sd_n = wr_data[DW-1];
    else if (auto_r && wrap)   sd_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_r <= '0; dhi_r <= '0; dlo_r <= '0; psel_r <= '0;
      pol_a_r <= 1'b0; pol_b_r <= 1'b0; en_r <= 1'b0;
      dead_r <= '0; auto_r <= 1'b0;
      src_r <= '0; st_a_r <= '0; st_b_r <= '0;
    end else if (clk_en && wr_en) begin
      case (wr_addr)
        3'd0: per_r <= wr_data[TW-1:0];
        3'd1: dhi_r <= wr_data[TW-1:0];
        3'd2: begin
          dlo_r   <= wr_data[1:0];
          psel_r  <= wr_data[3:2];
          pol_a_r <= wr_data[4];
          pol_b_r <= wr_data[5];
          en_r    <= wr_data[6];
        end
        3'd3: begin
          dead_r <= wr_data[DBW-1:0];
          auto_r <= wr_data[DW-1];
        end
        3'd4: begin
          src_r  <= wr_data[NSRC-1:0];
          st_a_r <= wr_data[4:3];
          st_b_r <= wr_data[6:5];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc <= '0; q <= '0; tmr <= '0; duty_act <= '0;
    end else if (clk_en) begin
      psc <= step ? 4'd0 : psc + 4'd1;
      if (step) begin
        q <= q + 2'd1;
        if (q == 2'd3) tmr <= (tmr == per_r) ? '0 : tmr + 1'b1;
      end
      if (wrap) duty_act <= {dhi_r, dlo_r};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) period_hit <= 1'b0;
    else        period_hit <= wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= 1'b0; wait_r <= 1'b0; dcnt <= '0;
      a_int <= 1'b0; b_int <= 1'b1;
    end else if (clk_en) begin
      if (raw != sel) begin
        sel  <= raw;
        dcnt <= 1;
        if (dead_r == '0) begin
          a_int <= raw; b_int <= !raw; wait_r <= 1'b0;
        end else begin
          a_int <= 1'b0; b_int <= 1'b0; wait_r <= 1'b1;
        end
      end else if (wait_r) begin
        if (dcnt == dead_r) begin
          a_int <= sel; b_int <= !sel; wait_r <= 1'b0;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd <= 1'b0; forced <= 1'b0;
    end else if (clk_en) begin
      sd <= sd_n;
      if (sd_n)      forced <= 1'b1;
      else if (wrap) forced <= 1'b0;
    end
  end

  always_comb begin
    if (!en_r) begin
      pwm_a = 1'b0; pwm_a_oe = 1'b0;
      pwm_b = 1'b0; pwm_b_oe = 1'b0;
    end else if (forced) begin
      pwm_a = (st_a_r == 2'b01); pwm_a_oe = !st_a_r[1];
      pwm_b = (st_b_r == 2'b01); pwm_b_oe = !st_b_r[1];
    end else begin
      pwm_a = a_int ^ pol_a_r; pwm_a_oe = 1'b1;
      pwm_b = b_int ^ pol_b_r; pwm_b_oe = 1'b1;
    end
  end

  assign shut_active = sd;
endmodule

// File: rtl/hb_pwm_guard_chk.sv
module hb_pwm_guard_chk #(
  parameter int TW   = 8,
  parameter int NSRC = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clk_en,
  input logic [NSRC-1:0] fault_in,
  input logic [NSRC-1:0] src_r,
  input logic            period_hit,
  input logic            shut_active,
  input logic [TW-1:0]   tmr,
  input logic [1:0]      q,
  input logic            a_int,
  input logic            b_int,
  input logic            sd,
  input logic            forced,
  input logic            wrap
);
  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    period_hit |=> !period_hit);

  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    period_hit |-> (tmr == '0 && q == 2'd0));

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_int && b_int));

  p_fault_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && |(fault_in & src_r)) |=> shut_active);

  p_release_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(forced) |-> $past(wrap));

  p_status_forces_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sd |-> forced);

  p_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable({tmr, q, a_int, b_int, sd, forced}));
endmodule

bind hb_pwm_guard hb_pwm_guard_chk #(.TW(TW), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .fault_in(fault_in),
  .src_r(src_r), .period_hit(period_hit), .shut_active(shut_active),
  .tmr(tmr), .q(q), .a_int(a_int), .b_int(b_int), .sd(sd),
  .forced(forced), .wrap(wrap)
);

// File: tb/hb_pwm_guard_test.sv
module hb_pwm_guard_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] fault_in = '0;
  logic pwm_a, pwm_a_oe, pwm_b, pwm_b_oe, period_hit, shut_active;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit cmp_on = 1'b0;

  hb_pwm_guard uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .fault_in(fault_in),
    .pwm_a(pwm_a), .pwm_a_oe(pwm_a_oe), .pwm_b(pwm_b), .pwm_b_oe(pwm_b_oe),
    .period_hit(period_hit), .shut_active(shut_active)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_per, m_dhi, m_dlo, m_ps, m_pa, m_pb, m_en, m_dead, m_auto, m_src, m_sta, m_stb;
  int m_psc, m_q, m_tmr, m_duty, m_sel, m_a, m_b, m_wait, m_cnt, m_sd, m_forced, m_hit;
  int t_div, t_step, t_wrap, t_raw, t_fh, t_sdn;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_per = 0; m_dhi = 0; m_dlo = 0; m_ps = 0; m_pa = 0; m_pb = 0; m_en = 0;
      m_dead = 0; m_auto = 0; m_src = 0; m_sta = 0; m_stb = 0;
      m_psc = 0; m_q = 0; m_tmr = 0; m_duty = 0; m_sel = 0; m_a = 0; m_b = 1;
      m_wait = 0; m_cnt = 0; m_sd = 0; m_forced = 0; m_hit = 0;
    end else begin
      t_div  = (m_ps == 0) ? 1 : (m_ps == 1) ? 4 : 16;
      t_step = (clk_en && m_psc == t_div - 1) ? 1 : 0;
      t_wrap = (t_step && m_q == 3 && m_tmr == m_per) ? 1 : 0;
      t_raw  = ((m_tmr * 4 + m_q) < m_duty) ? 1 : 0;
      t_fh   = ((int'(fault_in) & m_src) != 0) ? 1 : 0;
      m_hit  = t_wrap;
      if (clk_en) begin
        if (t_fh) t_sdn = 1;
        else if (wr_en && wr_addr == 4) t_sdn = int'(wr_data[7]);
        else if (m_auto && t_wrap) t_sdn = 0;
        else t_sdn = m_sd;
        if (t_sdn) m_forced = 1; else if (t_wrap) m_forced = 0;
        m_sd = t_sdn;
        if (t_raw != m_sel) begin
          m_sel = t_raw; m_cnt = 1;
          if (m_dead == 0) begin m_a = t_raw; m_b = 1 - t_raw; m_wait = 0; end
          else begin m_a = 0; m_b = 0; m_wait = 1; end
        end else if (m_wait) begin
          if (m_cnt == m_dead) begin m_a = m_sel; m_b = 1 - m_sel; m_wait = 0; end
          else m_cnt = (m_cnt + 1) % 128;
        end
        if (t_wrap) m_duty = m_dhi * 4 + m_dlo;
        if (t_step && m_q == 3) m_tmr = (m_tmr == m_per) ? 0 : (m_tmr + 1) % 256;
        if (t_step) m_q = (m_q + 1) % 4;
        m_psc = t_step ? 0 : (m_psc + 1) % 16;
        if (wr_en) begin
          case (int'(wr_addr))
            0: m_per = int'(wr_data);
            1: m_dhi = int'(wr_data);
            2: begin
              m_dlo = wr_data & 3; m_ps = (wr_data >> 2) & 3;
              m_pa = (wr_data >> 4) & 1; m_pb = (wr_data >> 5) & 1; m_en = (wr_data >> 6) & 1;
            end
            3: begin m_dead = wr_data & 127; m_auto = (wr_data >> 7) & 1; end
            4: begin m_src = wr_data & 7; m_sta = (wr_data >> 3) & 3; m_stb = (wr_data >> 5) & 3; end
            default: ;
          endcase
        end
      end
    end
  end

  int e_a, e_ao, e_b, e_bo;
  always @(negedge clk) begin
    if (cmp_on) begin
      if (!m_en) begin e_a = 0; e_ao = 0; e_b = 0; e_bo = 0; end
      else if (m_forced) begin
        e_a = (m_sta == 1); e_ao = (m_sta < 2);
        e_b = (m_stb == 1); e_bo = (m_stb < 2);
      end else begin
        e_a = m_a ^ m_pa; e_ao = 1; e_b = m_b ^ m_pb; e_bo = 1;
      end
      chk("pins R3 R4 R5 R6 R7 R9", int'({pwm_a, pwm_a_oe, pwm_b, pwm_b_oe}),
          e_a * 8 + e_ao * 4 + e_b * 2 + e_bo);
      chk("period_hit R2", int'(period_hit), m_hit);
      chk("shut_active R8 R10 R11", int'(shut_active), m_sd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog: actual %0d cycles expected under 50000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_hit();
    int k = 0;
    do begin @(negedge clk); k++; end while (!period_hit && k < 2000);
  endtask

  task automatic measure(output int a_hi, output int lo, output int b_hi);
    a_hi = 0; lo = 0; b_hi = 0;
    for (int i = 0; i < 16; i++) begin
      if (pwm_a) a_hi++;
      if (pwm_b) b_hi++;
      if (!pwm_a && !pwm_b) lo++;
      @(negedge clk);
    end
  endtask

  task automatic spacing(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!period_hit && n < 2000);
  endtask

  int ah, lo, bh, sp;
  logic [5:0] frozen;

  initial begin
    tick(3);
    chk("R1 reset outputs", int'({pwm_a, pwm_a_oe, pwm_b, pwm_b_oe, period_hit, shut_active}), 0);
    rst_n = 1'b1; cmp_on = 1'b1;

    wr(0, 3); wr(1, 1); wr(3, 2); wr(2, 8'h42);
    wait_hit(); wait_hit();
    measure(ah, lo, bh);
    chk("R3 A high cycles", ah, 4);
    chk("R5 both low cycles", lo, 4);
    chk("R5 B high cycles", bh, 8);
    wait_hit(); spacing(sp);
    chk("R2 period at divide 1", sp, 16);

    wr(2, 8'h46);
    wait_hit(); wait_hit(); spacing(sp);
    chk("R2 period at divide 4", sp, 64);
    wr(2, 8'h42); wait_hit(); wait_hit();

    wr(2, 8'h52); wait_hit();
    measure(ah, lo, bh);
    chk("R6 inverted A high cycles", ah, 12);
    chk("R6 B unaffected", bh, 8);
    wr(2, 8'h42);

    wr(2, 8'h02);
    chk("R7 disabled pins", int'({pwm_a, pwm_a_oe, pwm_b, pwm_b_oe}), 0);
    wr(2, 8'h42);

    wait_hit(); wait_hit();
    wr(1, 10); tick(14);
    chk("R4 old duty A at period end", int'(pwm_a), 0);
    chk("R4 old duty B at period end", int'(pwm_b), 1);
    wait_hit(); tick(8);
    chk("R3 full duty A", int'(pwm_a), 1);
    chk("R3 full duty B", int'(pwm_b), 0);
    wr(1, 1); wait_hit(); wait_hit();

    wr(4, 8'h49);
    fault_in = 3'b010; tick(1);
    chk("R8 unselected fault", int'(shut_active), 0);
    fault_in = 3'b001; tick(1);
    chk("R8 selected fault latches", int'(shut_active), 1);
    chk("R9 A forced high", int'({pwm_a, pwm_a_oe}), 3);
    chk("R9 B released", int'({pwm_b, pwm_b_oe}), 0);
    wr(4, 8'h21);
    chk("R9 A forced low B forced high", int'({pwm_a, pwm_a_oe, pwm_b, pwm_b_oe}), 7);
    wr(4, 8'h49);

    fault_in = 3'b000;
    wait_hit();
    wr(4, 8'h49);
    chk("R10 software clear status", int'(shut_active), 0);
    chk("R10 pins held until wrap", int'(pwm_b_oe), 0);
    wait_hit();
    chk("R10 pins released at wrap", int'({pwm_a_oe, pwm_b_oe}), 3);

    wr(4, 8'hC9);
    chk("R10 software force", int'({shut_active, pwm_b_oe}), 2);
    wait_hit(); wr(4, 8'h49); wait_hit();
    chk("R10 cleared after force", int'({shut_active, pwm_b_oe}), 1);

    wr(3, 8'h82);
    wait_hit();
    fault_in = 3'b001; tick(2);
    fault_in = 3'b000; tick(1);
    chk("R11 status held until wrap", int'(shut_active), 1);
    wait_hit();
    chk("R11 auto restart at wrap", int'({shut_active, pwm_b_oe}), 1);
    wr(3, 2);

    clk_en = 1'b0;
    frozen = {pwm_a, pwm_a_oe, pwm_b, pwm_b_oe, period_hit, shut_active};
    wr(1, 0); tick(19);
    chk("R12 outputs frozen", int'({pwm_a, pwm_a_oe, pwm_b, pwm_b_oe, period_hit, shut_active}),
        int'(frozen));
    clk_en = 1'b1;
    wait_hit(); wait_hit();
    measure(ah, lo, bh);
    chk("R12 write ignored while stopped", ah, 4);

    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule